// File: doc/BRIEF.md
# Timer Frame Access Gate

This block sits between a register bus and a bank of up to eight timer frames and decides, one access at a time, whether the access may touch the addressed register. Each access names a frame, a register group inside that frame, a direction, a security state and a view. The view is either the frame's primary view or its reduced second view. The gate replies one cycle later with a grant flag and, for the registers it owns, the read data. A refused read returns zero and a refused write changes nothing. No refusal raises a bus error.

Permission is layered. A secure-level bitmap first decides whether non-secure traffic may reach a frame at all; secure traffic skips this layer. Next, a per-frame permission byte grants reads of the counters, the frequency and the virtual offset, and grants read/write access to the two timer register groups. Last, a per-frame second-view control, written through the primary view, further narrows what the second view can see. That control also governs whether the frequency is visible there. A fixed capability parameter gives, for each frame, whether it exists, whether it has virtual features and whether it has a second view.

The gate also holds the control registers themselves: the bitmap, the permission bytes and the 64-bit virtual offsets. These are reached through a separate configuration port. The second-view controls live in the frames' own address space and are reached through the gated access path.

Top module: `tframe_gate`

## Requirements
- R1: After reset the bitmap, every permission byte, every second-view control and every virtual offset read as zero, and `rsp_valid` and `rsp_grant` are low.
- R2: An access is refused if its frame index is not below NUM_FRAMES, if the frame's capability byte (bits 8f+7..8f of TIMER_ID) has bit 0 clear, or if the selector is 7 (reserved). Selector codes: 0 physical count, 1 virtual count, 2 frequency, 3 virtual offset, 4 physical timer group, 5 virtual timer group, 6 second-view control.
- R3: A non-secure access (`acc_ns`=1) to frame f is refused unless bit f of the bitmap is set. A secure access ignores the bitmap.
- R4: In the primary view, reads of selectors 0, 1, 2 and 3 need permission-byte bits 0, 1, 2 and 3 respectively. Writes to selectors 0 to 3 are always refused.
- R5: Selector 4 needs permission-byte bit 5 and selector 5 needs bit 4, for both reads and writes.
- R6: Selectors 1, 3 and 5 are refused on a frame whose capability bit 1 is clear.
- R7: A second-view access is refused if capability bit 2 is clear. It is also refused if the primary-view rules would refuse it, and it is always refused for selectors 3 and 6. Beyond that it needs second-view control bit 0 for selector 0, bit 1 for selector 1, bit 0 or bit 1 for selector 2, bit 8 for selector 5 and bit 9 for selector 4.
- R8: Selector 6 in the primary view is readable and writable once the earlier layers pass. A write stores only data bits 0, 1, 8 and 9, and a read returns those bits in the same positions with every other bit zero.
- R9: Each cycle with `acc_valid` high gives exactly one cycle with `rsp_valid` high on the next cycle. A refused access has `rsp_rdata` zero and changes no state. Granted reads of selectors other than 3 and 6 also return zero.
- R10: A granted read of selector 3 returns the frame's full 64-bit virtual offset as last written through the configuration port.
- R11: The configuration map, on byte addresses, is: 0x04 bitmap (bits NUM_FRAMES-1..0); 0x08 and 0x0C capability word low and high halves, read-only; 0x40+4f permission byte of frame f (bits 5..0); 0x80+8f and 0x84+8f low and high halves of offset f. `cfg_rdata` shows the addressed register in the same cycle. Writes to read-only or unmapped addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 8 | Configuration byte address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| acc_valid | input | 1 | Access request present |
| acc_frame | input | 3 | Frame index |
| acc_sel | input | 3 | Register group selector |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_ns | input | 1 | 1 for a non-secure access |
| acc_view2 | input | 1 | 1 when the access arrives through the second view |
| acc_wdata | input | 10 | Write data for the second-view control |
| rsp_valid | output | 1 | Response present, one cycle after the request |
| rsp_grant | output | 1 | Access permitted |
| rsp_rdata | output | 64 | Read data, zero when refused |

## Verification
On every cycle the assertions check the response timing, zero data on a refusal, and that no grant ever reaches an absent frame or passes the non-secure bitmap without its bit. They also check that no write reaches a read-only selector, that the second view never exposes the offset or its own control, and that a second-view control only changes after a granted primary-view write. Whether each individual permission bit opens exactly its own register group can only be seen in the bench's sweeps. The same holds for the second-view bit pairing, the frequency rule, the offset read-back and the configuration map. Those sweeps cover every frame, selector, direction, security state and view under several permission patterns.

// File: rtl/tframe_pkg.sv
package tframe_pkg;

    localparam int TF_DW    = 32;
    localparam int TF_OW    = 2 * TF_DW;
    localparam int TF_PERMW = 6;
    localparam int TF_SVW   = 4;
    localparam int TF_SVDW  = 10;

    typedef enum logic [2:0] {
        SEL_PCNT  = 3'd0,
        SEL_VCNT  = 3'd1,
        SEL_FREQ  = 3'd2,
        SEL_VOFF  = 3'd3,
        SEL_PTMR  = 3'd4,
        SEL_VTMR  = 3'd5,
        SEL_SVCTL = 3'd6,
        SEL_RSVD  = 3'd7
    } tf_sel_e;

    typedef struct packed {
        logic has_view2;
        logic has_virt;
        logic present;
    } tf_caps_t;

    // compact second-view store: [0] phys count, [1] virt count, [2] virt timers, [3] phys timers
    function automatic logic [TF_SVW-1:0] sv_compact(input logic [TF_SVDW-1:0] raw);
        return {raw[9], raw[8], raw[1], raw[0]};
    endfunction

    function automatic logic [TF_SVDW-1:0] sv_expand(input logic [TF_SVW-1:0] c);
        return {c[3], c[2], 6'b000000, c[1], c[0]};
    endfunction

endpackage

// File: rtl/tframe_perm.sv
module tframe_perm
    import tframe_pkg::*;
(
    input  logic                in_range,
    input  tf_caps_t            caps,
    input  logic                ns_open,
    input  logic [TF_PERMW-1:0] perm,
    input  logic [TF_SVW-1:0]   svc,
    input  logic [2:0]          sel,
    input  logic                is_write,
    input  logic                is_ns,
    input  logic                is_view2,
    output logic                grant
);

    logic base_ok;
    logic virt_ok;
    logic dir_ok;
    logic first_ok;
    logic second_ok;
    logic needs_virt;
    logic read_only;

    always_comb begin
        needs_virt = (sel == SEL_VCNT) || (sel == SEL_VOFF) || (sel == SEL_VTMR);
        read_only  = (sel == SEL_PCNT) || (sel == SEL_VCNT) ||
                     (sel == SEL_FREQ) || (sel == SEL_VOFF);

        base_ok = in_range && caps.present && (sel != SEL_RSVD) &&
                  (!is_view2 || caps.has_view2) &&
                  (!is_ns || ns_open);
        virt_ok = !needs_virt || caps.has_virt;
        dir_ok  = !(is_write && read_only);

        unique case (sel)
            SEL_PCNT:  first_ok = perm[0];
            SEL_VCNT:  first_ok = perm[1];
            SEL_FREQ:  first_ok = perm[2];
            SEL_VOFF:  first_ok = perm[3];
            SEL_PTMR:  first_ok = perm[5];
            SEL_VTMR:  first_ok = perm[4];
            SEL_SVCTL: first_ok = 1'b1;
            default:   first_ok = 1'b0;
        endcase

        unique case (sel)
            SEL_PCNT: second_ok = svc[0];
            SEL_VCNT: second_ok = svc[1];
            SEL_FREQ: second_ok = svc[0] | svc[1];
            SEL_PTMR: second_ok = svc[3];
            SEL_VTMR: second_ok = svc[2];
            default:  second_ok = 1'b0;
        endcase

        grant = base_ok && virt_ok && dir_ok && first_ok && (!is_view2 || second_ok);
    end

endmodule

// File: rtl/tframe_cfg_map.sv
module tframe_cfg_map
    import tframe_pkg::*;
#(
    parameter int          NF       = 8,
    parameter logic [63:0] TIMER_ID = 64'h0007_0007_0105_0307
) (
    input  logic [7:0]                     addr,
    input  logic [NF-1:0]                  nsmap,
    input  logic [NF-1:0][TF_PERMW-1:0]    perm,
    input  logic [NF-1:0][TF_OW-1:0]       voff,
    output logic [TF_DW-1:0]               rdata,
    output logic                           hit_ns,
    output logic [NF-1:0]                  hit_perm,
    output logic [NF-1:0]                  hit_off_lo,
    output logic [NF-1:0]                  hit_off_hi
);

    localparam logic [7:0] ADDR_NS     = 8'h04;
    localparam logic [7:0] ADDR_CAP_LO = 8'h08;
    localparam logic [7:0] ADDR_CAP_HI = 8'h0C;
    localparam logic [7:0] ADDR_PERM   = 8'h40;
    localparam logic [7:0] ADDR_OFF    = 8'h80;

    always_comb begin
        rdata      = '0;
        hit_ns     = (addr == ADDR_NS);
        hit_perm   = '0;
        hit_off_lo = '0;
        hit_off_hi = '0;

        if (hit_ns)
            rdata = TF_DW'(nsmap);
        if (addr == ADDR_CAP_LO)
            rdata = TIMER_ID[TF_DW-1:0];
        if (addr == ADDR_CAP_HI)
            rdata = TIMER_ID[TF_OW-1:TF_DW];

        for (int f = 0; f < NF; f++) begin
            if (addr == ADDR_PERM + 8'(4 * f)) begin
                hit_perm[f] = 1'b1;
                rdata       = TF_DW'(perm[f]);
            end
            if (addr == ADDR_OFF + 8'(8 * f)) begin
                hit_off_lo[f] = 1'b1;
                rdata         = voff[f][TF_DW-1:0];
            end
            if (addr == ADDR_OFF + 8'(8 * f + 4)) begin
                hit_off_hi[f] = 1'b1;
                rdata         = voff[f][TF_OW-1:TF_DW];
            end
        end
    end

endmodule

// File: rtl/tframe_gate.sv
module tframe_gate
    import tframe_pkg::*;
#(
    parameter int          NUM_FRAMES = 8,
    parameter logic [63:0] TIMER_ID   = 64'h0007_0007_0105_0307
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [7:0]         cfg_addr,
    input  logic [TF_DW-1:0]   cfg_wdata,
    output logic [TF_DW-1:0]   cfg_rdata,
    input  logic               acc_valid,
    input  logic [2:0]         acc_frame,
    input  logic [2:0]         acc_sel,
    input  logic               acc_write,
    input  logic               acc_ns,
    input  logic               acc_view2,
    input  logic [TF_SVDW-1:0] acc_wdata,
    output logic               rsp_valid,
    output logic               rsp_grant,
    output logic [TF_OW-1:0]   rsp_rdata
);

    localparam int NF = NUM_FRAMES;

    typedef struct packed {
        logic [NF-1:0]                 nsmap;
        logic [NF-1:0][TF_PERMW-1:0]   perm;
        logic [NF-1:0][TF_SVW-1:0]     svc;
        logic [NF-1:0][TF_OW-1:0]      voff;
        logic                          rsp_valid;
        logic                          rsp_grant;
        logic [TF_OW-1:0]              rsp_rdata;
    } state_t;

    state_t state_d, state_q;

    tf_caps_t caps [NF];

    for (genvar g = 0; g < NF; g++) begin : g_caps
        assign caps[g] = '{has_view2: TIMER_ID[8*g+2],
                           has_virt:  TIMER_ID[8*g+1],
                           present:   TIMER_ID[8*g]};
    end

    // selected frame's controls
    logic                in_range;
    tf_caps_t            cur_caps;
    logic                cur_ns;
    logic [TF_PERMW-1:0] cur_perm;
    logic [TF_SVW-1:0]   cur_svc;
    logic [TF_OW-1:0]    cur_off;

    always_comb begin
        in_range = 1'b0;
        cur_caps = '0;
        cur_ns   = 1'b0;
        cur_perm = '0;
        cur_svc  = '0;
        cur_off  = '0;
        for (int f = 0; f < NF; f++) begin
            if (acc_frame == 3'(f)) begin
                in_range = 1'b1;
                cur_caps = caps[f];
                cur_ns   = state_q.nsmap[f];
                cur_perm = state_q.perm[f];
                cur_svc  = state_q.svc[f];
                cur_off  = state_q.voff[f];
            end
        end
    end

    logic grant;

    tframe_perm u_perm (
        .in_range (in_range),
        .caps     (cur_caps),
        .ns_open  (cur_ns),
        .perm     (cur_perm),
        .svc      (cur_svc),
        .sel      (acc_sel),
        .is_write (acc_write),
        .is_ns    (acc_ns),
        .is_view2 (acc_view2),
        .grant    (grant)
    );

    logic          hit_ns;
    logic [NF-1:0] hit_perm;
    logic [NF-1:0] hit_off_lo;
    logic [NF-1:0] hit_off_hi;

    tframe_cfg_map #(
        .NF       (NF),
        .TIMER_ID (TIMER_ID)
    ) u_cfg_map (
        .addr       (cfg_addr),
        .nsmap      (state_q.nsmap),
        .perm       (state_q.perm),
        .voff       (state_q.voff),
        .rdata      (cfg_rdata),
        .hit_ns     (hit_ns),
        .hit_perm   (hit_perm),
        .hit_off_lo (hit_off_lo),
        .hit_off_hi (hit_off_hi)
    );

    logic ok_now;

    always_comb begin
        state_d = state_q;
        ok_now  = acc_valid && grant;

        state_d.rsp_valid = acc_valid;
        state_d.rsp_grant = ok_now;
        state_d.rsp_rdata = '0;

        if (ok_now && !acc_write) begin
            if (acc_sel == SEL_VOFF)
                state_d.rsp_rdata = cur_off;
            else if (acc_sel == SEL_SVCTL)
                state_d.rsp_rdata = TF_OW'(sv_expand(cur_svc));
        end

        if (ok_now && acc_write && (acc_sel == SEL_SVCTL)) begin
            for (int f = 0; f < NF; f++) begin
                if (acc_frame == 3'(f))
                    state_d.svc[f] = sv_compact(acc_wdata);
            end
        end

        if (cfg_we) begin
            if (hit_ns)
                state_d.nsmap = cfg_wdata[NF-1:0];
            for (int f = 0; f < NF; f++) begin
                if (hit_perm[f])
                    state_d.perm[f] = cfg_wdata[TF_PERMW-1:0];
                if (hit_off_lo[f])
                    state_d.voff[f][TF_DW-1:0] = cfg_wdata;
                if (hit_off_hi[f])
                    state_d.voff[f][TF_OW-1:TF_DW] = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign rsp_valid = state_q.rsp_valid;
    assign rsp_grant = state_q.rsp_grant;
    assign rsp_rdata = state_q.rsp_rdata;

endmodule

// File: rtl/tframe_gate_chk.sv
module tframe_gate_chk
    import tframe_pkg::*;
#(
    parameter int          NF       = 8,
    parameter logic [63:0] TIMER_ID = 64'h0007_0007_0105_0307
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       acc_valid,
    input logic [2:0]                 acc_frame,
    input logic [2:0]                 acc_sel,
    input logic                       acc_write,
    input logic                       acc_ns,
    input logic                       acc_view2,
    input logic                       rsp_valid,
    input logic                       rsp_grant,
    input logic [TF_OW-1:0]           rsp_rdata,
    input logic [NF-1:0]              nsmap,
    input logic [NF-1:0][TF_SVW-1:0]  svc
);

    logic                      past_ok;
    logic                      valid_q;
    logic                      ns_q;
    logic                      v2_q;
    logic                      wr_q;
    logic [2:0]                sel_q;
    logic                      nsbit_q;
    logic                      present_q;
    logic                      svwr_q;
    logic [NF-1:0][TF_SVW-1:0] svc_prev;

    logic nsbit_c;
    logic present_c;

    always_comb begin
        nsbit_c   = 1'b0;
        present_c = 1'b0;
        for (int f = 0; f < NF; f++) begin
            if (acc_frame == 3'(f)) begin
                nsbit_c   = nsmap[f];
                present_c = TIMER_ID[8*f];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok   <= 1'b0;
            valid_q   <= 1'b0;
            ns_q      <= 1'b0;
            v2_q      <= 1'b0;
            wr_q      <= 1'b0;
            sel_q     <= '0;
            nsbit_q   <= 1'b0;
            present_q <= 1'b0;
            svwr_q    <= 1'b0;
            svc_prev  <= '0;
        end else begin
            past_ok   <= 1'b1;
            valid_q   <= acc_valid;
            ns_q      <= acc_ns;
            v2_q      <= acc_view2;
            wr_q      <= acc_write;
            sel_q     <= acc_sel;
            nsbit_q   <= nsbit_c;
            present_q <= present_c;
            svwr_q    <= acc_valid && acc_write && !acc_view2 && (acc_sel == SEL_SVCTL);
            svc_prev  <= svc;
        end
    end

    assert_rsp_timing_R9: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (rsp_valid == valid_q));

    assert_grant_needs_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_grant |-> rsp_valid);

    assert_deny_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_grant |-> (rsp_rdata == '0));

    assert_absent_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rsp_grant) |-> present_q);

    assert_ns_bitmap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rsp_grant && ns_q) |-> nsbit_q);

    assert_no_ro_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rsp_grant && wr_q) |-> (sel_q inside {SEL_PTMR, SEL_VTMR, SEL_SVCTL}));

    assert_view2_hidden_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && rsp_grant && v2_q) |-> !(sel_q inside {SEL_VOFF, SEL_SVCTL}));

    assert_svc_write_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && (svc != svc_prev)) |-> (svwr_q && rsp_grant));

endmodule

bind tframe_gate tframe_gate_chk #(
    .NF       (NUM_FRAMES),
    .TIMER_ID (TIMER_ID)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_frame (acc_frame),
    .acc_sel   (acc_sel),
    .acc_write (acc_write),
    .acc_ns    (acc_ns),
    .acc_view2 (acc_view2),
    .rsp_valid (rsp_valid),
    .rsp_grant (rsp_grant),
    .rsp_rdata (rsp_rdata),
    .nsmap     (state_q.nsmap),
    .svc       (state_q.svc)
);

// File: tb/tframe_gate_bench.sv
module tframe_gate_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [63:0] CAPS       = 64'h0007_0007_0105_0307;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_frame = '0;
    logic [2:0]  acc_sel = '0;
    logic        acc_write = 1'b0;
    logic        acc_ns = 1'b0;
    logic        acc_view2 = 1'b0;
    logic [9:0]  acc_wdata = '0;
    logic        rsp_valid;
    logic        rsp_grant;
    logic [63:0] rsp_rdata;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    logic [7:0]  m_ns;
    logic [5:0]  m_perm [8];
    logic [3:0]  m_sv   [8];
    logic [63:0] m_off  [8];

    always #(CLK_PERIOD / 2) clk = ~clk;

    tframe_gate u_tframe_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .acc_valid (acc_valid),
        .acc_frame (acc_frame),
        .acc_sel   (acc_sel),
        .acc_write (acc_write),
        .acc_ns    (acc_ns),
        .acc_view2 (acc_view2),
        .acc_wdata (acc_wdata),
        .rsp_valid (rsp_valid),
        .rsp_grant (rsp_grant),
        .rsp_rdata (rsp_rdata)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected grant from the requirement text
    function automatic logic model(input int f, input int s, input bit wr, input bit ns,
                                   input bit v2, output string tag);
        logic [7:0] cap;
        bit need_v, ro, fv, sv2;
        cap    = CAPS[f*8 +: 8];
        need_v = (s == 1) || (s == 3) || (s == 5);
        ro     = (s <= 3);
        case (s)
            0: fv = m_perm[f][0];
            1: fv = m_perm[f][1];
            2: fv = m_perm[f][2];
            3: fv = m_perm[f][3];
            4: fv = m_perm[f][5];
            5: fv = m_perm[f][4];
            6: fv = 1'b1;
            default: fv = 1'b0;
        endcase
        case (s)
            0: sv2 = m_sv[f][0];
            1: sv2 = m_sv[f][1];
            2: sv2 = m_sv[f][0] | m_sv[f][1];
            4: sv2 = m_sv[f][3];
            5: sv2 = m_sv[f][2];
            default: sv2 = 1'b0;
        endcase
        if (s <= 3)      tag = "R4";
        else if (s <= 5) tag = "R5";
        else if (s == 6) tag = "R8";
        else             tag = "R2";
        if (!cap[0] || s == 7) begin tag = "R2"; return 1'b0; end
        if (v2 && !cap[2])     begin tag = "R7"; return 1'b0; end
        if (ns && !m_ns[f])    begin tag = "R3"; return 1'b0; end
        if (need_v && !cap[1]) begin tag = "R6"; return 1'b0; end
        if (wr && ro)          begin tag = "R4"; return 1'b0; end
        if (!fv) return 1'b0;
        if (v2) begin tag = "R7"; return sv2; end
        return 1'b1;
    endfunction

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        cfg_we    = 1'b1;
        cfg_addr  = a;
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic cfg_check(input logic [7:0] a, input logic [31:0] exp, input string tag);
        cfg_addr = a;
        #1;
        check(tag, 64'(cfg_rdata), 64'(exp));
    endtask

    task automatic access(input int f, input int s, input bit wr, input bit ns,
                          input bit v2, input logic [9:0] wd);
        string       tag;
        logic        g;
        logic [63:0] exp_d;
        g = model(f, s, wr, ns, v2, tag);
        exp_d = '0;
        if (g && !wr && s == 3) exp_d = m_off[f];
        if (g && !wr && s == 6) exp_d = {54'b0, m_sv[f][3], m_sv[f][2], 6'b0, m_sv[f][1], m_sv[f][0]};
        acc_valid = 1'b1;
        acc_frame = 3'(f);
        acc_sel   = 3'(s);
        acc_write = wr;
        acc_ns    = ns;
        acc_view2 = v2;
        acc_wdata = wd;
        @(negedge clk);
        acc_valid = 1'b0;
        check("R9_valid", 64'(rsp_valid), 64'd1);
        check(tag, 64'(rsp_grant), 64'(g));
        check((s == 3) ? "R10" : "R9", rsp_rdata, exp_d);
        if (g && wr && s == 6) m_sv[f] = {wd[9], wd[8], wd[1], wd[0]};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        m_ns = '0;
        for (int f = 0; f < 8; f++) begin
            m_perm[f] = '0;
            m_sv[f]   = '0;
            m_off[f]  = '0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", 64'(rsp_valid), 64'd0);
        check("R1", 64'(rsp_grant), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        cfg_check(8'h04, 32'h0, "R1");
        for (int f = 0; f < 8; f++) begin
            cfg_check(8'(8'h40 + 4 * f), 32'h0, "R1");
            cfg_check(8'(8'h80 + 8 * f), 32'h0, "R1");
            cfg_check(8'(8'h84 + 8 * f), 32'h0, "R1");
        end
        // R1: second-view controls start at zero
        access(0, 6, 1'b0, 1'b0, 1'b0, 10'h0);
        // R11: capability word is read-only, unmapped writes are dropped
        cfg_check(8'h08, CAPS[31:0], "R11");
        cfg_check(8'h0C, CAPS[63:32], "R11");
        cfg_write(8'h08, 32'hFFFF_FFFF);
        cfg_write(8'h20, 32'hFFFF_FFFF);
        cfg_write(8'hFC, 32'hFFFF_FFFF);
        cfg_check(8'h08, CAPS[31:0], "R11");
        cfg_check(8'h04, 32'h0, "R11");
        cfg_check(8'h40, 32'h0, "R11");
        // R9: idle cycle gives no response
        @(negedge clk);
        check("R9", 64'(rsp_valid), 64'd0);

        for (int c = 0; c < 4; c++) begin
            int k;
            case (c)
                0: m_ns = 8'hFF;
                1: m_ns = 8'hA5;
                2: m_ns = 8'h3C;
                default: m_ns = 8'h00;
            endcase
            cfg_write(8'h04, {24'h0, m_ns});
            cfg_check(8'h04, {24'h0, m_ns}, "R11");
            for (int f = 0; f < 8; f++) begin
                if ((f + c) % 3 == 0) m_perm[f] = 6'h3F;
                else                  m_perm[f] = 6'((f * 13 + c * 29) ^ 6'h2A);
                m_off[f] = {32'hA000_0000 | 32'(f << 8) | 32'(c), 32'h1234_5600 + 32'(f * 16 + c)};
                cfg_write(8'(8'h40 + 4 * f), {26'h3FF_FFFF, m_perm[f]});
                cfg_write(8'(8'h80 + 8 * f), m_off[f][31:0]);
                cfg_write(8'(8'h84 + 8 * f), m_off[f][63:32]);
                cfg_check(8'(8'h40 + 4 * f), {26'h0, m_perm[f]}, "R11");
                cfg_check(8'(8'h84 + 8 * f), m_off[f][63:32], "R11");
                // secure primary-view write of the second-view control (R8)
                access(f, 6, 1'b1, 1'b0, 1'b0, 10'(f * 97 + c * 211) | 10'h0FC);
            end
            k = 0;
            for (int f = 0; f < 8; f++)
                for (int s = 0; s < 8; s++)
                    for (int wr = 0; wr < 2; wr++)
                        for (int ns = 0; ns < 2; ns++)
                            for (int v2 = 0; v2 < 2; v2++) begin
                                access(f, s, wr[0], ns[0], v2[0], 10'(k * 37 + c * 5) ^ 10'h303);
                                k++;
                            end
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule